// File: doc/BRIEF.md
# Copper Port Crossover and Link Bring-up Sequencer

This controller brings up a twisted-pair LAN port whose cable may be straight or crossed. After a start pulse it drives the crossover select line low (MDI). It waits a fixed number of millisecond ticks and then reads the PHY basic status register through a management read port. If the link bit is clear, it flips the select line between MDI and MDIX and tries again. When a bounded number of attempts all fail, it raises `fail`.

Once link is seen, the sequencer reads the status register again to confirm that negotiation or parallel detection has completed. It then decodes the operating mode from a vendor mode register and resolves pause support through a chain of up to three further reads. The result is published as a four-bit port status word, and `done` is raised. The management serial protocol sits behind the read port and is not part of this block.

The request side of the read port is valid/ready. `rd_valid` rises with `rd_addr` and both hold unchanged until a cycle in which `rd_ready` is high. The response side is also valid/ready. `rsp_ready` is high only while one accepted request waits for its data, and a response is taken in a cycle where `rsp_valid` and `rsp_ready` are both high. The responder may stall either side for any number of cycles. Only one request is ever outstanding.

Top module: `xover_link_seq`

## Requirements
- R1: After reset, and in the cycle after an accepted `start` pulse, `status`, `done` and `fail` read zero and `xover_sel` is low (MDI). `start` is accepted only while no search is running.
- R2: Each link attempt is preceded by exactly WAIT_MS ticks of `ms_tick` counted after entering the wait, and then reads register 1.
- R3: A register 1 response with bit 2 clear inverts `xover_sel`. A response with bit 2 set leaves it unchanged.
- R4: After MAX_TRIES link checks that all had bit 2 clear, `fail` is set, `done` stays low, and no further reads are issued.
- R5: After link is seen, register 1 is read a second time. If that read has bit 5 clear, `done` is set with `status` zero and register 31 is never read.
- R6: With bit 5 set, register 31 bits 4:2 set the mode, where status bit 1 is 100 Mbit/s and bit 2 is full duplex. Code 1 gives neither, 5 gives full duplex only, 2 gives 100 Mbit/s only, and 6 gives both. Any other code gives neither.
- R7: Register 6 is read only if the second register 1 read had bit 3 set. Register 4 is read only if register 6 bit 0 is set. Register 5 is read only if register 4 bit 10 is set. Status bit 3 (pause) equals register 5 bit 10 when register 5 is read, and is 0 otherwise.
- R8: Whenever negotiation completed (bit 5 set), the sequence ends with status bit 0 (link) set and `done` high.
- R9: `rd_addr` stays stable while `rd_valid` waits for `rd_ready`, and `rd_valid` and `rsp_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a search |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| rd_valid | output | 1 | Register read request valid |
| rd_addr | output | 5 | PHY register address of the request |
| rd_ready | input | 1 | Request accepted by the management master |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 16 | Read data |
| rsp_ready | output | 1 | Sequencer waits for read data |
| xover_sel | output | 1 | Crossover select: 0 = MDI, 1 = MDIX |
| status | output | 4 | Bit 0 link, bit 1 100 Mbit/s, bit 2 full duplex, bit 3 pause |
| done | output | 1 | Search ended with link found |
| fail | output | 1 | Search ended without link |

## Verification
A wrong attempt counter or wait timer shows up as the wrong number of register 1 reads before `fail`, or as a first read that arrives at the wrong tick, within one wait window. A mis-sequenced state shows up at the read port: a register read that the previous response should have suppressed, or one missing from the chain. The wrong value of `xover_sel` or `status` appears within a cycle of the response that decided it. A broken handshake holder shows up as an address change or a lost response in the same cycle as the stall.

// File: rtl/xover_pkg.sv
package xover_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] REG_BSR  = 5'd1;
  localparam logic [ADDR_W-1:0] REG_ADV  = 5'd4;
  localparam logic [ADDR_W-1:0] REG_LPA  = 5'd5;
  localparam logic [ADDR_W-1:0] REG_EXP  = 5'd6;
  localparam logic [ADDR_W-1:0] REG_MODE = 5'd31;

  localparam int BIT_LINK  = 2;
  localparam int BIT_ABIL  = 3;
  localparam int BIT_CMPL  = 5;
  localparam int BIT_PNEG  = 0;
  localparam int BIT_PAUSE = 10;
  localparam int MODE_LO   = 2;

  localparam int ST_LINK  = 0;
  localparam int ST_SPD   = 1;
  localparam int ST_FDX   = 2;
  localparam int ST_PAUSE = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_LINK, S_ANEG, S_MODE, S_EXP, S_ADV, S_LPA
  } seq_state_t;
endpackage

// File: rtl/ms_wait_timer.sv
module ms_wait_timer #(
  parameter int WAIT_MS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = (WAIT_MS > 1) ? $clog2(WAIT_MS + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT_MS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (tick)         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign expire = run && tick && (cnt == LAST);

  assert_tick_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/mgmt_read_port.sv
module mgmt_read_port #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] go_addr,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          rsp_ready,
  output logic          got,
  output logic [DW-1:0] got_data
);
  logic          pend_req, pend_rsp;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_req <= 1'b0;
      pend_rsp <= 1'b0;
      addr_q   <= '0;
    end else begin
      if (go && !pend_req && !pend_rsp) begin
        pend_req <= 1'b1;
        addr_q   <= go_addr;
      end
      if (pend_req && rd_ready) begin
        pend_req <= 1'b0;
        pend_rsp <= 1'b1;
      end
      if (pend_rsp && rsp_valid) pend_rsp <= 1'b0;
    end
  end

  assign rd_valid  = pend_req;
  assign rd_addr   = addr_q;
  assign rsp_ready = pend_rsp;
  assign got       = pend_rsp && rsp_valid;
  assign got_data  = rsp_data;

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rsp_ready));
endmodule

// File: rtl/speed_mode_decode.sv
module speed_mode_decode (
  input  logic [2:0] code,
  output logic       spd100,
  output logic       fdx
);
  always_comb begin
    spd100 = 1'b0;
    fdx    = 1'b0;
    case (code)
      3'd1: ;
      3'd5: fdx = 1'b1;
      3'd2: spd100 = 1'b1;
      3'd6: begin spd100 = 1'b1; fdx = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/xover_link_seq.sv
module xover_link_seq
  import xover_pkg::*;
#(
  parameter int MAX_TRIES = 100,
  parameter int WAIT_MS   = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ms_tick,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ready,
  output logic              xover_sel,
  output logic [3:0]        status,
  output logic              done,
  output logic              fail
);
  localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES + 1) : 1;
  localparam logic [TW-1:0] TRY_LAST = TW'(MAX_TRIES - 1);

  seq_state_t        state;
  logic [TW-1:0]     tries;
  logic              abil;
  logic              go_q;
  logic [ADDR_W-1:0] go_addr_q;
  logic              expire, got;
  logic [DATA_W-1:0] got_data;
  logic              dec_spd, dec_fdx;

  ms_wait_timer #(.WAIT_MS(WAIT_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == S_WAIT), .tick(ms_tick), .expire(expire)
  );

  mgmt_read_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go_q), .go_addr(go_addr_q),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .got(got), .got_data(got_data)
  );

  speed_mode_decode u_dec (
    .code(got_data[MODE_LO+2:MODE_LO]), .spd100(dec_spd), .fdx(dec_fdx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tries     <= '0;
      abil      <= 1'b0;
      go_q      <= 1'b0;
      go_addr_q <= '0;
      xover_sel <= 1'b0;
      status    <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state     <= S_WAIT;
          tries     <= '0;
          abil      <= 1'b0;
          xover_sel <= 1'b0;
          status    <= '0;
          done      <= 1'b0;
          fail      <= 1'b0;
        end
        S_WAIT: if (expire) begin
          state     <= S_LINK;
          go_q      <= 1'b1;
          go_addr_q <= REG_BSR;
        end
        S_LINK: if (got) begin
          if (got_data[BIT_LINK]) begin
            state     <= S_ANEG;
            go_q      <= 1'b1;
            go_addr_q <= REG_BSR;
          end else begin
            xover_sel <= ~xover_sel;
            if (tries == TRY_LAST) begin
              fail  <= 1'b1;
              state <= S_IDLE;
            end else begin
              tries <= tries + 1'b1;
              state <= S_WAIT;
            end
          end
        end
        S_ANEG: if (got) begin
          if (!got_data[BIT_CMPL]) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            abil      <= got_data[BIT_ABIL];
            state     <= S_MODE;
            go_q      <= 1'b1;
            go_addr_q <= REG_MODE;
          end
        end
        S_MODE: if (got) begin
          status[ST_SPD] <= dec_spd;
          status[ST_FDX] <= dec_fdx;
          if (abil) begin
            state     <= S_EXP;
            go_q      <= 1'b1;
            go_addr_q <= REG_EXP;
          end else begin
            status[ST_LINK] <= 1'b1;
            done            <= 1'b1;
            state           <= S_IDLE;
          end
        end
        S_EXP: if (got) begin
          if (got_data[BIT_PNEG]) begin
            state     <= S_ADV;
            go_q      <= 1'b1;
            go_addr_q <= REG_ADV;
          end else begin
            status[ST_LINK] <= 1'b1;
            done            <= 1'b1;
            state           <= S_IDLE;
          end
        end
        S_ADV: if (got) begin
          if (got_data[BIT_PAUSE]) begin
            state     <= S_LPA;
            go_q      <= 1'b1;
            go_addr_q <= REG_LPA;
          end else begin
            status[ST_LINK] <= 1'b1;
            done            <= 1'b1;
            state           <= S_IDLE;
          end
        end
        S_LPA: if (got) begin
          status[ST_PAUSE] <= got_data[BIT_PAUSE];
          status[ST_LINK]  <= 1'b1;
          done             <= 1'b1;
          state            <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_fail_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_fail_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !rd_valid);

  assert_xover_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LINK && got && !got_data[BIT_LINK]) |=> (xover_sel != $past(xover_sel)));

  assert_xover_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LINK && got && got_data[BIT_LINK]) |=> $stable(xover_sel));

  assert_done_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MODE && got && !abil) |=> (done && status[ST_LINK]));
endmodule

// File: tb/sim_xover_link_seq.sv
`timescale 1ns/1ps
module sim_xover_link_seq;
  localparam int TRIES = 4;
  localparam int WMS   = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ms_tick = 1'b0;
  logic rd_ready = 1'b0, rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic rd_valid, rsp_ready, xover_sel, done, fail;
  logic [4:0] rd_addr;
  logic [3:0] status;

  int n_cmp = 0, n_bad = 0;
  int tick_count = 0;
  int rd_cnt [32];
  int seq_no = 0;

  logic link_en = 1'b0, want_x = 1'b0;
  logic [15:0] r1_base = '0, r31 = '0, r6 = '0, r4 = '0, r5 = '0;

  always #10 clk = ~clk;

  xover_link_seq #(.MAX_TRIES(TRIES), .WAIT_MS(WMS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .xover_sel(xover_sel), .status(status), .done(done), .fail(fail)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_val(input logic [4:0] a);
    case (a)
      5'd1:  reg_val = r1_base | {13'd0, (link_en && (xover_sel == want_x)), 2'b00};
      5'd31: reg_val = r31;
      5'd6:  reg_val = r6;
      5'd4:  reg_val = r4;
      5'd5:  reg_val = r5;
      default: reg_val = 16'h0;
    endcase
  endfunction

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      ms_tick = 1'b1;
      tick_count++;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        automatic logic [4:0] a = rd_addr;
        automatic int dly = seq_no % 3;
        seq_no++;
        repeat (dly) @(negedge clk);
        chk("R9 addr held", {rd_valid, rd_addr}, {1'b1, a});
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        rd_cnt[a]++;
        repeat (dly) @(negedge clk);
        rsp_data  = reg_val(a);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic setup(input logic le, input logic wx, input logic [15:0] b1,
                       input logic [2:0] code, input logic [15:0] v6,
                       input logic [15:0] v4, input logic [15:0] v5);
    link_en = le; want_x = wx; r1_base = b1;
    r31 = {11'd0, code, 2'b00}; r6 = v6; r4 = v4; r5 = v5;
    foreach (rd_cnt[i]) rd_cnt[i] = 0;
  endtask

  int tick_base;
  task automatic kick();
    @(posedge ms_tick);
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    tick_base = tick_count;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fail) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("end reached", int'(done || fail), 1);
  endtask

  localparam logic [15:0] CMPL = 16'h0020, ABIL = 16'h0008;
  localparam logic [15:0] PB = 16'h0400;

  task automatic t_reset();
    chk("R1 reset status", status, 0);
    chk("R1 reset flags", {done, fail, xover_sel, rd_valid}, 0);
  endtask

  task automatic t_mdi_full();
    setup(1, 0, CMPL | ABIL, 3'd6, 16'h1, PB, PB);
    kick();
    while (!rd_valid) @(negedge clk);
    chk("R2 ticks before first read", tick_count - tick_base, WMS);
    chk("R2 first read addr", rd_addr, 1);
    wait_end();
    chk("R6 R7 R8 status full", status, 4'b1111);
    chk("R3 stays MDI", xover_sel, 0);
    chk("R8 done", {done, fail}, 2'b10);
    chk("R7 lpa read", rd_cnt[5], 1);
  endtask

  task automatic t_mdix_10h();
    setup(1, 1, CMPL, 3'd1, 16'h1, PB, PB);
    kick();
    chk("R1 cleared after start", {status, done, fail, xover_sel}, 0);
    wait_end();
    chk("R3 switched to MDIX", xover_sel, 1);
    chk("R6 10 half", status, 4'b0001);
    chk("R2 R5 reg1 reads", rd_cnt[1], 3);
    chk("R7 no exp read", rd_cnt[6], 0);
  endtask

  task automatic t_aneg_open();
    setup(1, 0, ABIL, 3'd6, 16'h1, PB, PB);
    kick();
    wait_end();
    chk("R5 done", {done, fail}, 2'b10);
    chk("R5 status zero", status, 0);
    chk("R5 no mode read", rd_cnt[31], 0);
  endtask

  task automatic t_mode(input logic [2:0] code, input logic [3:0] exp);
    setup(1, 0, CMPL, code, 0, 0, 0);
    kick();
    wait_end();
    chk($sformatf("R6 code %0d", code), status, exp);
  endtask

  task automatic t_pause_partial();
    setup(1, 0, CMPL | ABIL, 3'd5, 16'h1, PB, 16'h0);
    kick();
    wait_end();
    chk("R7 partner no pause", status, 4'b0101);
    chk("R7 lpa read once", rd_cnt[5], 1);
    setup(1, 0, CMPL | ABIL, 3'd5, 16'h0, PB, PB);
    kick();
    wait_end();
    chk("R7 no adv read", rd_cnt[4], 0);
    chk("R7 pause clear", status, 4'b0101);
  endtask

  task automatic t_fail();
    setup(0, 0, CMPL, 3'd6, 0, 0, 0);
    kick();
    wait_end();
    chk("R4 fail set", {done, fail}, 2'b01);
    chk("R4 attempts", rd_cnt[1], TRIES);
    chk("R3 final select", xover_sel, TRIES % 2);
    repeat (60) @(negedge clk);
    chk("R4 no more reads", rd_cnt[1], TRIES);
    chk("R4 still failed", {done, fail}, 2'b01);
  endtask

  initial begin
    foreach (rd_cnt[i]) rd_cnt[i] = 0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mdi_full();
    t_mdix_10h();
    t_aneg_open();
    t_mode(3'd2, 4'b0011);
    t_mode(3'd5, 4'b0101);
    t_mode(3'd3, 4'b0001);
    t_mode(3'd0, 4'b0001);
    t_pause_partial();
    t_fail();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule